// File: doc/BRIEF.md
# Soft-Bit Depuncturer

This block rebuilds the soft-bit stream of a rate-1/2 mother convolutional code from a punctured stream of signed 8-bit soft values. A receiver places it between the deinterleaver and a fixed rate-1/2 trellis decoder. For every trellis step it emits one pair of soft values, A and B, one for each mother-code output. Positions that the transmitter removed are filled with the value 0. On a signed soft scale 0 means "no information", so the decoder weighs both branch hypotheses equally there. Because of this, one rate-1/2 decoder can serve code rates 1/2, 2/3 and 3/4 without any change.

Soft values enter on a valid/ready stream, one per beat, and pairs leave on a second valid/ready stream. Back-pressure rules:
- An input beat transfers on a clock edge where `in_valid` and `in_ready` are both high.
- A pair transfers on a clock edge where `out_valid` and `out_ready` are both high.
- Once a pair is offered, it stays unchanged until it is taken.
- The input is held off in two cases: while the current pattern slot is a deleted position, and while the B slot is waiting for the output register to free.

`frame_start` is a plain one-cycle control pulse. It returns the puncturing pattern to its first slot and drops any half-built pair. The rate select should only change together with it.

Top module: `soft_depuncturer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1, because the pattern starts at step 0, slot A.
- R2: With `rate_sel` = 0 (rate 1/2), every pair is two consecutive input values, the earlier one on `out_a`.
- R3: With `rate_sel` = 1 (rate 2/3), each three inputs x0 x1 x2 give the pairs (x0,x1) and then (x2,0).
- R4: With `rate_sel` = 2 (rate 3/4), each four inputs x0..x3 give the pairs (x0,x1), (x2,0) and then (0,x3).
- R5: While the pattern is at a deleted slot, `in_ready` is 0 and no input is consumed.
- R6: During a `frame_start` cycle `in_ready` is 0. After it, the pattern restarts at step 0, slot A, and any value already collected for an unfinished pair is discarded.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_a` and `out_b` hold their values.
- R8: A B-slot input is accepted only when the output register is empty or is being emptied in the same cycle. No input value is lost or duplicated under any pattern of stalls.
- R9: `rate_sel` = 3 behaves exactly as rate 1/2.
- R10: Soft values pass through bit-exact over the full signed range, including -128 (8'h80) and 127 (8'h7F).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that restarts the puncturing pattern |
| rate_sel | input | 2 | 0: rate 1/2, 1: rate 2/3, 2: rate 3/4, 3: same as 0 |
| in_valid | input | 1 | Input soft value is valid |
| in_ready | output | 1 | Block accepts the input soft value |
| in_soft | input | 8 | Signed punctured soft value |
| out_valid | output | 1 | Output pair is valid |
| out_ready | input | 1 | Consumer accepts the pair |
| out_a | output | 8 | Soft value for mother-code output A |
| out_b | output | 8 | Soft value for mother-code output B |

## Verification
The bench compares every pair against a pattern built from the input sequence. A wrong placement of the deleted slot would show up as a zero in the wrong half of a pair, or as pairs shifted across the stream. The bench holds the input valid during a deleted slot; a design that did not stall there would swallow a real value and replace it with the dummy. The bench pulses `frame_start` after a lone A value; a design that kept the stale half-pair would pair it with the next frame's first value. Random input gaps combined with output back-pressure expose a B slot that overwrites a pair not yet taken, or an output that changes while it is stalled.

// File: rtl/depunc_pkg.sv
package depunc_pkg;

  typedef enum logic [1:0] {
    RATE_1_2  = 2'd0,
    RATE_2_3  = 2'd1,
    RATE_3_4  = 2'd2,
    RATE_ALT  = 2'd3
  } rate_e;

  localparam int MAX_PERIOD = 3;
  localparam int PHASE_W    = $clog2(MAX_PERIOD);

  // number of trellis steps in one puncturing period
  function automatic logic [PHASE_W-1:0] steps_of(rate_e r);
    case (r)
      RATE_2_3: steps_of = PHASE_W'(2);
      RATE_3_4: steps_of = PHASE_W'(3);
      default:  steps_of = PHASE_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/depunc_pattern.sv
module depunc_pattern
  import depunc_pkg::*;
(
  input  logic [1:0]         rate_sel,
  input  logic [PHASE_W-1:0] phase,
  input  logic               slot_b,
  output logic               keep,
  output logic               last_step
);

  rate_e rate;
  assign rate = rate_e'(rate_sel);

  // a phase beyond the period (after an unannounced rate change) wraps too
  assign last_step = (phase >= steps_of(rate) - PHASE_W'(1));

  always_comb begin
    keep = 1'b1;
    case (rate)
      RATE_2_3: if (slot_b && phase == PHASE_W'(1)) keep = 1'b0;
      RATE_3_4: begin
        if (slot_b && phase == PHASE_W'(1))  keep = 1'b0;
        if (!slot_b && phase == PHASE_W'(2)) keep = 1'b0;
      end
      default:  keep = 1'b1;
    endcase
  end

endmodule

// File: rtl/depunc_phase.sv
module depunc_phase
  import depunc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               advance,
  input  logic               last_step,
  output logic [PHASE_W-1:0] phase,
  output logic               slot_b
);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      phase  <= '0;
      slot_b <= 1'b0;
    end else if (advance) begin
      if (slot_b) begin
        slot_b <= 1'b0;
        phase  <= last_step ? '0 : phase + PHASE_W'(1);
      end else begin
        slot_b <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/depunc_pair_reg.sv
module depunc_pair_reg #(
  parameter int SOFT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_a,
  input  logic              load_b,
  input  logic [SOFT_W-1:0] value,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [SOFT_W-1:0] out_a,
  output logic [SOFT_W-1:0] out_b,
  output logic              out_free
);

  logic [SOFT_W-1:0] a_hold;

  assign out_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_hold <= '0;
    end else if (load_a) begin
      a_hold <= value;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_a     <= '0;
      out_b     <= '0;
    end else if (load_b) begin
      out_valid <= 1'b1;
      out_a     <= a_hold;
      out_b     <= value;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/soft_depuncturer.sv
module soft_depuncturer
  import depunc_pkg::*;
#(
  parameter int          SOFT_W    = 8,
  parameter logic [7:0]  DUMMY_VAL = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [1:0]        rate_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SOFT_W-1:0] in_soft,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SOFT_W-1:0] out_a,
  output logic [SOFT_W-1:0] out_b
);

  localparam logic [SOFT_W-1:0] FILL = SOFT_W'(DUMMY_VAL);

  logic [PHASE_W-1:0] phase;
  logic               slot_b;
  logic               keep;
  logic               last_step;
  logic               out_free;
  logic               space;
  logic               advance;
  logic [SOFT_W-1:0]  value;

  depunc_pattern u_pattern (
    .rate_sel  (rate_sel),
    .phase     (phase),
    .slot_b    (slot_b),
    .keep      (keep),
    .last_step (last_step)
  );

  depunc_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (frame_start),
    .advance   (advance),
    .last_step (last_step),
    .phase     (phase),
    .slot_b    (slot_b)
  );

  // slot A only fills the hold register; slot B needs the output register
  assign space    = !slot_b || out_free;
  assign advance  = !frame_start && space && (!keep || in_valid);
  assign in_ready = !frame_start && keep && space;
  assign value    = keep ? in_soft : FILL;

  depunc_pair_reg #(.SOFT_W(SOFT_W)) u_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_a    (advance && !slot_b),
    .load_b    (advance && slot_b),
    .value     (value),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_a     (out_a),
    .out_b     (out_b),
    .out_free  (out_free)
  );

endmodule

// File: rtl/depunc_checker.sv
module depunc_checker
  import depunc_pkg::*;
#(
  parameter int SOFT_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [SOFT_W-1:0]  out_a,
  input logic [SOFT_W-1:0]  out_b,
  input logic               keep,
  input logic               slot_b,
  input logic [PHASE_W-1:0] phase
);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_a) && $stable(out_b));

  p_frame_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !in_ready);

  p_frame_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (phase == '0) && !slot_b);

  p_dummy_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !keep |-> !in_ready);

  p_b_space_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && slot_b |-> (!out_valid || out_ready));

  p_a_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    keep && !slot_b && !frame_start |-> in_ready);

endmodule

bind soft_depuncturer depunc_checker #(.SOFT_W(SOFT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_a       (out_a),
  .out_b       (out_b),
  .keep        (keep),
  .slot_b      (slot_b),
  .phase       (phase)
);

// File: tb/sim_soft_depuncturer.sv
module sim_soft_depuncturer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_soft = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_a;
  logic [7:0] out_b;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  soft_depuncturer u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .rate_sel    (rate_sel),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_soft     (in_soft),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_a       (out_a),
    .out_b       (out_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_frame(input int rate);
    @(posedge clk); #1;
    rate_sel = rate[1:0];
    frame_start = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b0, "R6 in_ready during frame_start", int'(in_ready), 0);
    @(posedge clk); #1;
    frame_start = 1'b0;
  endtask

  task automatic send_one(input logic [7:0] v);
    int guard = 0;
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_soft = v;
    @(negedge clk);
    while (!in_ready && guard < 100) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // expected pairs per rate: 0/3 -> (d0,d1); 1 -> (d0,d1)(d2,0); 2 -> (d0,d1)(d2,0)(0,d3)
  task automatic run_seg(input int rate, input int groups, input int rdy_mod,
                         input bit extreme, input string req);
    logic [7:0] din[$];
    logic [7:0] ea[$];
    logic [7:0] eb[$];
    int k;
    int idx = 0;
    int oidx = 0;
    int guard = 0;
    k = (rate == 1) ? 3 : (rate == 2) ? 4 : 2;
    for (int i = 0; i < groups * k; i++) begin
      if (extreme) din.push_back((i % 2 == 0) ? 8'h80 : 8'h7F);
      else         din.push_back(8'($urandom));
    end
    for (int g = 0; g < groups; g++) begin
      ea.push_back(din[g*k]);
      eb.push_back(din[g*k+1]);
      if (rate == 1 || rate == 2) begin
        ea.push_back(din[g*k+2]);
        eb.push_back(8'h00);
      end
      if (rate == 2) begin
        ea.push_back(8'h00);
        eb.push_back(din[g*k+3]);
      end
    end
    pulse_frame(rate);
    while ((idx < din.size() || oidx < ea.size()) && guard < 20000) begin
      @(posedge clk); #1;
      in_valid  = (idx < din.size()) && ($urandom % 4 != 0);
      in_soft   = (idx < din.size()) ? din[idx] : 8'h00;
      out_ready = (rdy_mod == 0) ? 1'b1 : ($urandom % rdy_mod != 0);
      @(negedge clk);
      if (in_valid && in_ready) idx++;
      if (out_valid && out_ready) begin
        if (oidx < ea.size()) begin
          check(out_a == ea[oidx], {req, " out_a"}, int'(out_a), int'(ea[oidx]));
          check(out_b == eb[oidx], {req, " out_b"}, int'(out_b), int'(eb[oidx]));
        end else begin
          check(1'b0, {req, " extra pair"}, oidx, ea.size());
        end
        oidx++;
      end
      guard++;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    out_ready = 1'b0;
    check(oidx == ea.size(), {req, " pair count"}, oidx, ea.size());
    check(idx == din.size(), {req, " input count R8"}, idx, din.size());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // R5: deleted slot at rate 2/3 stalls the input, then emits (x2,0)
    out_ready = 1'b1;
    pulse_frame(1);
    send_one(8'd1);
    send_one(8'd2);
    send_one(8'd3);
    @(posedge clk); #1;
    in_soft = 8'd4;
    @(negedge clk);
    check(in_ready == 1'b0, "R5 in_ready at deleted slot", int'(in_ready), 0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid && out_a == 8'd3, "R3 dummy pair out_a", int'(out_a), 3);
    check(out_b == 8'd0, "R5 dummy value", int'(out_b), 0);
    @(posedge clk); #1;
    out_ready = 1'b0;

    // R6: frame_start drops a lone A value
    pulse_frame(0);
    send_one(8'h11);
    pulse_frame(0);
    send_one(8'h22);
    send_one(8'h33);
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid && out_a == 8'h22, "R6 stale A discarded", int'(out_a), 'h22);
    check(out_b == 8'h33, "R6 pair B", int'(out_b), 'h33);

    // R7 / R8: hold under back-pressure, B blocked while full
    send_one(8'h44);
    @(posedge clk); #1;
    in_soft = 8'h55;
    @(negedge clk);
    check(in_ready == 1'b0, "R8 B slot blocked while full", int'(in_ready), 0);
    check(out_valid && out_a == 8'h22 && out_b == 8'h33, "R7 held pair",
          int'({out_a, out_b}), 'h2233);
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R8 B slot open when draining", int'(in_ready), 1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    out_ready = 1'b0;
    @(negedge clk);
    check(out_valid && out_a == 8'h44 && out_b == 8'h55, "R8 next pair",
          int'({out_a, out_b}), 'h4455);
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b0;

    run_seg(0, 20, 0, 1'b0, "R2 rate1/2 full speed");
    run_seg(0, 30, 3, 1'b0, "R2 rate1/2 stalls");
    run_seg(1, 20, 3, 1'b0, "R3 rate2/3 stalls");
    run_seg(1, 15, 0, 1'b0, "R3 rate2/3 full speed");
    run_seg(2, 20, 2, 1'b0, "R4 rate3/4 stalls");
    run_seg(2, 15, 0, 1'b0, "R4 rate3/4 full speed");
    run_seg(3, 15, 4, 1'b0, "R9 rate code 3");
    run_seg(2, 6, 3, 1'b1, "R10 extreme values");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule